// File: doc/BRIEF.md
# Strobe-Ordered DRAM Cycle Decoder with Parallel Test Mode

This block is a synthesizable behavioural model of the control side of an asynchronous DRAM. A fast system clock samples the active-low row strobe, column strobe, write enable and output enable. Each falling edge of the row strobe is classified by the levels of the column strobe and write enable in that sample. The outcome is one of three cycles: a row access (the row is latched from the address bus), an internal-counter refresh, or a test-mode entry. Column cycles under an open row read and write a small internal cell array. Several column cycles may follow one row opening.

A compressed test mode can be entered through the strobe ordering. In this mode the two lowest column bits are ignored. A write stores each data bit into the four cells of its group, and a read reports, bit by bit, whether those four cells agree. Either kind of refresh cycle returns the block to normal operation. The refresh row counter and the test-mode flag are brought out so that the surrounding logic can follow refresh progress and mode changes.

Top module: `dram_strobe_decoder`

## Requirements
- R1: After reset, data_oe_o is 0, test_mode_o is 0 and rfsh_row_o is 0.
- R2: A row-strobe fall with the column strobe high latches the row from addr_i. Each column-strobe fall under that open row accesses the cell {row, addr_i}. A later read returns the data written there, also when several columns are accessed in one row opening.
- R3: A row-strobe fall with the column strobe low and write enable high is an internal refresh. It advances rfsh_row_o by one and clears test_mode_o.
- R4: The refresh counter wraps from ROWS-1 to 0.
- R5: A row-strobe fall with both the column strobe and write enable low sets test_mode_o and also advances the refresh counter.
- R6: A row opening with no column-strobe fall before the row strobe rises clears test_mode_o. A row opening that does contain a column cycle leaves test_mode_o unchanged.
- R7: In test mode, column bits [1:0] are ignored, and a write stores data_i into all four columns {addr_i[COL_W-1:2], 0..3}.
- R8: In test mode, a read returns in bit b a 1 when bit b of the four cells of the group is equal in all four, and 0 otherwise.
- R9: If write enable is low when the column strobe falls (early write), data_oe_o stays 0 for the whole column cycle and the data is stored.
- R10: If write enable falls while a read column cycle is active, data_o keeps the data read at the column-strobe fall, and data_i is written to the latched column.
- R11: data_oe_o is 1 only while a read column cycle is active and oe_ni is low. It returns to 0 one clock after the column strobe is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Multiplexed row / column address |
| data_i | input | DW | Write data |
| data_o | output | DW | Read data or per-bit test result |
| data_oe_o | output | 1 | High when data_o is driven (low means high impedance) |
| test_mode_o | output | 1 | Parallel test mode active |
| rfsh_row_o | output | ROW_W | Next row used by internal refresh |

## Verification
The three strobe orderings at the row-strobe fall are each driven, and the mode flag and counter are observed after each one. This separates refresh from mode entry and tests the counter wrap. Test-mode reads are run against a group written uniformly in test mode and against a group that was disturbed by a normal write. This shows the compare acting per bit and the low column bits being ignored. Early writes, late write-enable falls during reads and output-enable toggling under an active column strobe distinguish the output gating cases.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;
  typedef enum logic [1:0] {
    CYC_ROW  = 2'd0,
    CYC_CBR  = 2'd1,
    CYC_WCBR = 2'd2
  } cyc_e;
endpackage

// File: rtl/dram_cells.sv
module dram_cells #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int DW   = 4,
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(COLS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_bcast_i,
  input  logic [RW-1:0] wr_row_i,
  input  logic [CW-1:0] wr_col_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [RW-1:0] rd_row_i,
  input  logic [CW-1:0] rd_col_i,
  output logic [DW-1:0] rd_norm_o,
  output logic [DW-1:0] rd_cmp_o
);
  localparam int DEPTH = 2 ** (RW + CW);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] grp [4];

  // R7: broadcast writes land in every cell of the 4-column group
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem <= '{default: '0};
    end else if (wr_en_i) begin
      for (int g = 0; g < 4; g++) begin
        if (wr_bcast_i || wr_col_i[1:0] == 2'(g))
          mem[{wr_row_i, wr_col_i[CW-1:2], 2'(g)}] <= wr_data_i;
      end
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_grp
    assign grp[g] = mem[{rd_row_i, rd_col_i[CW-1:2], 2'(g)}];
  end

  assign rd_norm_o = mem[{rd_row_i, rd_col_i}];
  // R8: per-bit agreement of the four cells
  assign rd_cmp_o  = ~((grp[0] ^ grp[1]) | (grp[0] ^ grp[2]) | (grp[0] ^ grp[3]));
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_dec_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int DW   = 4,
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(COLS),
  localparam int AW  = (RW > CW) ? RW : CW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ras_ni,
  input  logic          cas_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] rd_norm_i,
  input  logic [DW-1:0] rd_cmp_i,
  output logic          wr_en_o,
  output logic          wr_bcast_o,
  output logic [RW-1:0] wr_row_o,
  output logic [CW-1:0] wr_col_o,
  output logic [DW-1:0] wr_data_o,
  output logic [RW-1:0] rd_row_o,
  output logic [CW-1:0] rd_col_o,
  output logic [DW-1:0] rd_data_o,
  output logic          drive_o,
  output logic          test_mode_o,
  output logic [RW-1:0] rfsh_row_o
);
  logic ras_q, cas_q, we_q;
  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  logic row_act_q, col_act_q, early_q, cas_seen_q, test_q;
  cyc_e kind_q;
  logic [RW-1:0] row_q, ctr_q, ctr_nxt;
  logic [CW-1:0] col_q;
  logic [DW-1:0] rd_q;
  logic is_row_cyc, col_start, early_wr, late_wr;

  assign ras_fall = ras_q & ~ras_ni;
  assign ras_rise = ~ras_q & ras_ni;
  assign cas_fall = cas_q & ~cas_ni;
  assign cas_rise = ~cas_q & cas_ni;
  assign we_fall  = we_q & ~we_ni;

  assign is_row_cyc = row_act_q && (kind_q == CYC_ROW);
  assign col_start  = cas_fall && is_row_cyc;
  assign early_wr   = col_start && !we_ni;
  assign late_wr    = we_fall && col_act_q && !early_q && is_row_cyc && !cas_ni;
  assign ctr_nxt    = (ctr_q == RW'(ROWS - 1)) ? '0 : ctr_q + RW'(1);

  assign wr_en_o    = early_wr | late_wr;
  assign wr_bcast_o = test_q;
  assign wr_row_o   = row_q;
  assign wr_col_o   = early_wr ? addr_i[CW-1:0] : col_q;
  assign wr_data_o  = data_i;
  assign rd_row_o   = row_q;
  assign rd_col_o   = addr_i[CW-1:0];
  assign rd_data_o  = rd_q;
  assign drive_o    = col_act_q & ~early_q;
  assign test_mode_o = test_q;
  assign rfsh_row_o  = ctr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q <= 1'b1; cas_q <= 1'b1; we_q <= 1'b1;
      row_act_q <= 1'b0; col_act_q <= 1'b0; early_q <= 1'b0;
      cas_seen_q <= 1'b0; test_q <= 1'b0; kind_q <= CYC_ROW;
      row_q <= '0; col_q <= '0; ctr_q <= '0; rd_q <= '0;
    end else begin
      ras_q <= ras_ni; cas_q <= cas_ni; we_q <= we_ni;
      if (ras_fall) begin
        row_act_q  <= 1'b1;
        cas_seen_q <= 1'b0;
        if (cas_ni) begin
          kind_q <= CYC_ROW;
          row_q  <= addr_i[RW-1:0];
        end else if (we_ni) begin
          kind_q <= CYC_CBR;
          test_q <= 1'b0;
          ctr_q  <= ctr_nxt;
        end else begin
          kind_q <= CYC_WCBR;
          test_q <= 1'b1;
          ctr_q  <= ctr_nxt;
        end
      end else if (ras_rise) begin
        row_act_q <= 1'b0;
        // row opening without any column cycle acts as a RAS-only refresh
        if (kind_q == CYC_ROW && !cas_seen_q) test_q <= 1'b0;
      end
      if (col_start) begin
        col_act_q  <= 1'b1;
        cas_seen_q <= 1'b1;
        col_q      <= addr_i[CW-1:0];
        early_q    <= !we_ni;
        rd_q       <= test_q ? rd_cmp_i : rd_norm_i;
      end else if (cas_rise) begin
        col_act_q <= 1'b0;
        early_q   <= 1'b0;
      end
    end
  end

  assert_cbr_clears_test_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_fall && !cas_ni && we_ni) |=> !test_mode_o);
  assert_cbr_advance_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_fall && !cas_ni && ctr_q != RW'(ROWS - 1)) |=> rfsh_row_o == $past(rfsh_row_o) + RW'(1));
  assert_ctr_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_fall && !cas_ni && ctr_q == RW'(ROWS - 1)) |=> rfsh_row_o == '0);
  assert_wcbr_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_fall && !cas_ni && !we_ni) |=> test_mode_o);
  assert_early_hiz_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_start && !we_ni) |=> !drive_o);
  assert_row_keeps_ctr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_fall && cas_ni) |=> $stable(rfsh_row_o));
endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int DW   = 4,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(COLS),
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  output logic [DW-1:0]     data_o,
  output logic              data_oe_o,
  output logic              test_mode_o,
  output logic [ROW_W-1:0]  rfsh_row_o
);
  logic             wr_en, wr_bcast, drive;
  logic [ROW_W-1:0] wr_row, rd_row;
  logic [COL_W-1:0] wr_col, rd_col;
  logic [DW-1:0]    wr_data, rd_norm, rd_cmp;

  dram_ctrl #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_ctrl (
    .clk_i, .rst_ni, .ras_ni, .cas_ni, .we_ni, .addr_i, .data_i,
    .rd_norm_i(rd_norm), .rd_cmp_i(rd_cmp),
    .wr_en_o(wr_en), .wr_bcast_o(wr_bcast), .wr_row_o(wr_row), .wr_col_o(wr_col),
    .wr_data_o(wr_data), .rd_row_o(rd_row), .rd_col_o(rd_col),
    .rd_data_o(data_o), .drive_o(drive), .test_mode_o, .rfsh_row_o
  );

  dram_cells #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_cells (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_bcast_i(wr_bcast), .wr_row_i(wr_row), .wr_col_i(wr_col),
    .wr_data_i(wr_data), .rd_row_i(rd_row), .rd_col_i(rd_col),
    .rd_norm_o(rd_norm), .rd_cmp_o(rd_cmp)
  );

  assign data_oe_o = drive & ~oe_ni;

  assert_cas_high_hiz_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_ni && $past(cas_ni)) |-> !data_oe_o);
endmodule

// File: tb/tb_dram_strobe_decoder.sv
`timescale 1ns/1ps
module tb_dram_strobe_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [2:0] addr = '0;
  logic [3:0] din = '0;
  logic [3:0] dout;
  logic doe, tmode;
  logic [2:0] rrow;
  int checks = 0, failures = 0;
  int exp_ctr = 0;

  always #2.5 clk = ~clk;

  dram_strobe_decoder #(.ROWS(8), .COLS(8), .DW(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n), .we_ni(we_n),
    .oe_ni(oe_n), .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe),
    .test_mode_o(tmode), .rfsh_row_o(rrow)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic ras_open(input logic [2:0] r);
    addr = r; ras_n = 1'b0; tick();
  endtask

  task automatic ras_close();
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; ras_n = 1'b1; tick(); tick();
  endtask

  task automatic col_write(input logic [2:0] c, input logic [3:0] d);
    addr = c; din = d; we_n = 1'b0; oe_n = 1'b0; cas_n = 1'b0; tick();
    check("R9 early write output", {7'd0, doe}, 8'd0);
    tick();
    check("R9 early write output", {7'd0, doe}, 8'd0);
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tick();
  endtask

  task automatic col_read(input logic [2:0] c, output logic [3:0] d);
    addr = c; we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0; tick();
    d = dout;
    check("R11 read drives", {7'd0, doe}, 8'd1);
    cas_n = 1'b1; tick();
    check("R11 release after strobe", {7'd0, doe}, 8'd0);
    oe_n = 1'b1;
  endtask

  task automatic refresh(input logic we_lvl);
    cas_n = 1'b0; we_n = we_lvl; tick();
    ras_n = 1'b0; tick();
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; tick(); tick();
    exp_ctr = (exp_ctr + 1) % 8;
  endtask

  task automatic t_reset();
    check("R1 data_oe", {7'd0, doe}, 8'd0);
    check("R1 test_mode", {7'd0, tmode}, 8'd0);
    check("R1 rfsh_row", {5'd0, rrow}, 8'd0);
  endtask

  task automatic t_rw();
    logic [3:0] d;
    ras_open(3'd2); col_write(3'd5, 4'hA); ras_close();
    ras_open(3'd2); col_read(3'd5, d); ras_close();
    check("R2 read back", {4'd0, d}, 8'h0A);
    ras_open(3'd2);
    addr = 3'd5; we_n = 1'b1; oe_n = 1'b1; cas_n = 1'b0; tick();
    check("R11 oe high blocks", {7'd0, doe}, 8'd0);
    oe_n = 1'b0; tick();
    check("R11 oe low drives", {7'd0, doe}, 8'd1);
    check("R11 data", {4'd0, dout}, 8'h0A);
    cas_n = 1'b1; tick();
    check("R11 cas high releases", {7'd0, doe}, 8'd0);
    ras_close();
    check("R2 row access keeps counter", {5'd0, rrow}, 8'(exp_ctr));
  endtask

  task automatic t_page();
    logic [3:0] d0, d1;
    ras_open(3'd3);
    col_write(3'd0, 4'h3); col_write(3'd1, 4'hC);
    col_read(3'd0, d0); col_read(3'd1, d1);
    ras_close();
    check("R2 page col0", {4'd0, d0}, 8'h03);
    check("R2 page col1", {4'd0, d1}, 8'h0C);
  endtask

  task automatic t_cbr();
    for (int i = 0; i < 7; i++) refresh(1'b1);
    check("R3 counter advance", {5'd0, rrow}, 8'd7);
    check("R3 no test mode", {7'd0, tmode}, 8'd0);
    refresh(1'b1);
    check("R4 counter wrap", {5'd0, rrow}, 8'd0);
  endtask

  task automatic t_test_write();
    logic [3:0] d;
    refresh(1'b0);
    check("R5 test mode set", {7'd0, tmode}, 8'd1);
    check("R5 counter advance", {5'd0, rrow}, 8'(exp_ctr));
    ras_open(3'd1); col_write(3'd6, 4'b0110); col_read(3'd4, d); ras_close();
    check("R8 uniform group passes", {4'd0, d}, 8'h0F);
    check("R6 column cycle keeps test mode", {7'd0, tmode}, 8'd1);
    refresh(1'b1);
    check("R3 refresh exits test mode", {7'd0, tmode}, 8'd0);
    for (int c = 4; c < 8; c++) begin
      ras_open(3'd1); col_read(3'(c), d); ras_close();
      check("R7 broadcast cell", {4'd0, d}, 8'h06);
    end
  endtask

  task automatic t_test_fail();
    logic [3:0] d;
    ras_open(3'd1); col_write(3'd5, 4'b0011); ras_close();
    refresh(1'b0);
    ras_open(3'd1); col_read(3'd7, d); ras_close();
    check("R8 per-bit compare", {4'd0, d}, 8'b0000_1010);
    ras_open(3'd0); tick(); ras_close();
    check("R6 row-only refresh exits", {7'd0, tmode}, 8'd0);
    check("R6 counter unchanged", {5'd0, rrow}, 8'(exp_ctr));
  endtask

  task automatic t_rmw();
    logic [3:0] d;
    ras_open(3'd4); col_write(3'd2, 4'h9); ras_close();
    ras_open(3'd4);
    addr = 3'd2; we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0; tick();
    check("R10 read phase", {3'd0, doe, dout}, 8'h19);
    din = 4'h5; we_n = 1'b0; tick(); tick();
    check("R10 read data held", {3'd0, doe, dout}, 8'h19);
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tick();
    ras_close();
    ras_open(3'd4); col_read(3'd2, d); ras_close();
    check("R10 late write stored", {4'd0, d}, 8'h05);
  endtask

  initial begin
    fork
      begin
        repeat (3) tick();
        rst_n = 1'b1; tick();
        t_reset();
        t_rw();
        t_page();
        t_cbr();
        t_test_write();
        t_test_fail();
        t_rmw();
      end
      begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule